// File: doc/BRIEF.md
# Page Access Permission and Fault Status Unit

This block sits after the page table walker of a memory management unit. For each translated access it receives the kind of access (data read, data write, instruction fetch, or write with fetch, each as user or supervisor), the 3-bit permission code and modified flag of the final page entry, and any error the walker reported. It decides whether the access is legal. It produces an error code and the page rights that may be installed for the access.

On a fault, the block updates a fault status word and a fault address. It then either raises an instruction or data trap, or, when no-fault mode is on or traps are disabled, grants the access full rights at base-page granularity and suppresses the trap. Reading the status word clears it. A second fault that arrives before the word was read marks the word as overflowed.

All results are registered. They appear one clock after the request strobe.

Top module: `mmu_perm_fault`

## Requirements
- R1: A user access (supervisor bit low) with permission code 6 or 7 and no walker error yields error code 12 (privilege violation).
- R2: Otherwise, error code 8 (protection) is given when the rights that the code grants lack a needed right: read for a data read, write for a write, execute for a fetch, and both write and execute for a write with fetch. Code 4 grants execute only.
- R3: A permission error (8 or 12) on a user access is ignored while no-fault mode is set. The error is 0, there is no trap, and the status word is not updated.
- R4: Rights are 3 bits: bit 0 read, bit 1 write, bit 2 execute. Supervisor rights for codes 0..7 are R, RW, RX, RWX, X, RW, RX, RWX. User rights match these, except that code 5 gives R only and codes 6 and 7 give none.
- R5: The write right is withheld while the entry's modified flag is clear.
- R6: A non-zero walker error type (1 invalid, 4 translation error) takes precedence over the permission check and yields error code type×4. It is not ignored by no-fault mode.
- R7: On a fault, the status word becomes: 1 if it was non-zero and not being read in that cycle (otherwise 0), ORed with the access index {write,fetch,supervisor} in bits 7:5, the error code in bits 4:2, the valid flag in bit 1, and, for walker errors only, the walker level in bits 9:8.
- R8: On a fault, the fault address takes the request address with its page-offset bits cleared. Otherwise it holds its value.
- R9: A faulting access while no-fault mode is set or traps are disabled gets rights 3'b111 and the override flag, and raises no trap.
- R10: Any other faulting access raises a one-cycle instruction trap if it was a fetch, and a data trap if it was not. A faulting access never raises both.
- R11: The status read strobe clears the status word. A fault in the same cycle is recorded without the overflow bit.
- R12: Response outputs, traps, status and address update on the first clock edge after a request. Without a request, the response valid flag, the traps and the override flag stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | Access is a write |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_super | input | 1 | Access is in supervisor mode |
| pte_perm | input | 3 | Permission code of the page entry |
| pte_modified | input | 1 | Modified flag of the page entry |
| nofault_mode | input | 1 | No-fault mode enable |
| trap_en | input | 1 | Traps enabled |
| walk_level | input | LVL_W | Level at which the walk stopped |
| walk_err | input | 3 | Walker error type, 0 when none |
| req_vaddr | input | VA_W | Virtual address of the access |
| fsr_rd | input | 1 | Status read strobe, clears the status word |
| rsp_valid | output | 1 | Response valid |
| rsp_err | output | 5 | Error code |
| rsp_rights | output | 3 | Granted rights {x,w,r} |
| rsp_override | output | 1 | Fault overridden with full rights |
| itrap | output | 1 | Instruction fault trap request |
| dtrap | output | 1 | Data fault trap request |
| fault_status | output | LVL_W+8 | Fault status word |
| fault_addr | output | VA_W | Page-aligned fault address |

## Verification
Every result of this block (error, rights, override, traps, status word, fault address) is due exactly one clock edge after the request. The bench changes inputs on the falling edge and samples one time unit after the following rising edge, so each check sees the first registered value. The directed tests sample rsp_valid and the traps again one edge later, to confirm that they drop. The overflow and read-clear tests also check the status word at the edge after each strobe, because it accumulates across requests.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  localparam int LVL_W = 2;
  localparam int ERR_W = 5;
  localparam int FSR_W = LVL_W + 8;

  localparam logic [ERR_W-1:0] ERR_NONE = 5'd0;
  localparam logic [ERR_W-1:0] ERR_PROT = 5'd8;
  localparam logic [ERR_W-1:0] ERR_PRIV = 5'd12;

  // bit0 read, bit1 write, bit2 execute
  typedef logic [2:0] rights_t;
  localparam int RB_R = 0;
  localparam int RB_W = 1;
  localparam int RB_X = 2;

  localparam rights_t RT_NONE = 3'b000;
  localparam rights_t RT_R    = 3'b001;
  localparam rights_t RT_RW   = 3'b011;
  localparam rights_t RT_RX   = 3'b101;
  localparam rights_t RT_RWX  = 3'b111;
  localparam rights_t RT_X    = 3'b100;

  function automatic rights_t code_rights(input logic user, input logic [2:0] code);
    rights_t r;
    case (code)
      3'd0: r = RT_R;
      3'd1: r = RT_RW;
      3'd2: r = RT_RX;
      3'd3: r = RT_RWX;
      3'd4: r = RT_X;
      3'd5: r = user ? RT_R : RT_RW;
      3'd6: r = user ? RT_NONE : RT_RX;
      default: r = user ? RT_NONE : RT_RWX;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mpf_check.sv
module mpf_check
  import mpf_pkg::*;
(
  input  logic             acc_write,
  input  logic             acc_fetch,
  input  logic             acc_super,
  input  logic [2:0]       perm,
  input  logic             modified,
  input  logic             nofault,
  input  logic [2:0]       walk_err,
  output logic [ERR_W-1:0] err_code,
  output logic             fault,
  output rights_t          granted
);
  logic    user;
  rights_t tbl;
  rights_t need;
  logic    missing;
  logic    priv_viol;
  logic [ERR_W-1:0] perm_err;

  always_comb begin
    user      = !acc_super;
    tbl       = code_rights(user, perm);
    need      = '0;
    need[RB_R] = !acc_write && !acc_fetch;
    need[RB_W] = acc_write;
    need[RB_X] = acc_fetch;
    missing   = |(need & ~tbl);
    priv_viol = user && (perm[2:1] == 2'b11);
    if (priv_viol)    perm_err = ERR_PRIV;
    else if (missing) perm_err = ERR_PROT;
    else              perm_err = ERR_NONE;

    if (walk_err != 3'd0) begin
      err_code = {walk_err, 2'b00};
      fault    = 1'b1;
    end else if (perm_err != ERR_NONE && !(nofault && user)) begin
      err_code = perm_err;
      fault    = 1'b1;
    end else begin
      err_code = ERR_NONE;
      fault    = 1'b0;
    end

    granted = tbl;
    if (!modified) granted[RB_W] = 1'b0;
  end
endmodule

// File: rtl/mpf_status.sv
module mpf_status
  import mpf_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fault_we,
  input  logic [2:0]       acc_idx,
  input  logic [ERR_W-1:0] err_code,
  input  logic             use_level,
  input  logic [LVL_W-1:0] level,
  input  logic             rd,
  input  logic [VA_W-1:0]  vaddr,
  output logic [FSR_W-1:0] status,
  output logic [VA_W-1:0]  addr
);
  localparam int HI_W = VA_W - PAGE_SHIFT;

  logic [FSR_W-1:0] fields;
  logic [FSR_W-1:0] carry;
  logic [LVL_W-1:0] lvl_eff;

  always_comb begin
    lvl_eff = use_level ? level : '0;
    fields  = {lvl_eff, acc_idx, err_code[4:2], 2'b10};
    carry   = (status != '0 && !rd) ? FSR_W'(1) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      addr   <= '0;
    end else if (fault_we) begin
      status <= carry | fields;
      addr   <= {vaddr[VA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
    end else if (rd) begin
      status <= '0;
    end
  end

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;

  // R7
  fav_set_chk: assert property (@(posedge clk) disable iff (rst)
    fault_we |=> status[1]);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_we && !rd && status != '0) |=> status[0]);
  // R11
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd && !fault_we) |=> status == '0);
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_we |=> $stable(addr));
endmodule

// File: rtl/mmu_perm_fault.sv
module mmu_perm_fault
  import mpf_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_fetch,
  input  logic             req_super,
  input  logic [2:0]       pte_perm,
  input  logic             pte_modified,
  input  logic             nofault_mode,
  input  logic             trap_en,
  input  logic [LVL_W-1:0] walk_level,
  input  logic [2:0]       walk_err,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             fsr_rd,
  output logic             rsp_valid,
  output logic [ERR_W-1:0] rsp_err,
  output logic [2:0]       rsp_rights,
  output logic             rsp_override,
  output logic             itrap,
  output logic             dtrap,
  output logic [FSR_W-1:0] fault_status,
  output logic [VA_W-1:0]  fault_addr
);
  logic [ERR_W-1:0] c_err;
  logic             c_fault;
  rights_t          c_granted;
  logic             ovr;
  logic [2:0]       acc_idx;

  assign acc_idx = {req_write, req_fetch, req_super};
  assign ovr     = nofault_mode || !trap_en;

  mpf_check u_check (
    .acc_write (req_write),
    .acc_fetch (req_fetch),
    .acc_super (req_super),
    .perm      (pte_perm),
    .modified  (pte_modified),
    .nofault   (nofault_mode),
    .walk_err  (walk_err),
    .err_code  (c_err),
    .fault     (c_fault),
    .granted   (c_granted)
  );

  mpf_status #(.VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_status (
    .clk       (clk),
    .rst       (rst),
    .fault_we  (req_valid && c_fault),
    .acc_idx   (acc_idx),
    .err_code  (c_err),
    .use_level (walk_err != 3'd0),
    .level     (walk_level),
    .rd        (fsr_rd),
    .vaddr     (req_vaddr),
    .status    (fault_status),
    .addr      (fault_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_err      <= '0;
      rsp_rights   <= '0;
      rsp_override <= 1'b0;
      itrap        <= 1'b0;
      dtrap        <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_override <= 1'b0;
      itrap        <= 1'b0;
      dtrap        <= 1'b0;
      if (req_valid) begin
        rsp_err <= c_err;
        if (!c_fault)  rsp_rights <= c_granted;
        else if (ovr)  rsp_rights <= RT_RWX;
        else           rsp_rights <= RT_NONE;
        rsp_override <= c_fault && ovr;
        itrap        <= c_fault && !ovr && req_fetch;
        dtrap        <= c_fault && !ovr && !req_fetch;
      end
    end
  end

  // R10
  trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(itrap && dtrap));
  // R10
  trap_has_err_chk: assert property (@(posedge clk) disable iff (rst)
    (itrap || dtrap) |-> (rsp_valid && rsp_err != '0));
  // R9
  override_rights_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_override |-> (rsp_rights == 3'b111 && !itrap && !dtrap));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !itrap && !dtrap && !rsp_override));
  // R12
  rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
endmodule

// File: tb/tb_mmu_perm_fault.sv
module tb_mmu_perm_fault;
  localparam int CLK_PERIOD = 10;
  localparam int VA_W = 32;
  localparam int NV = 22;

  // {idx{w,f,s}, perm, mod, nf, ten, werr, lvl, err, rights, it, dt, ovr}
  localparam logic [24:0] VEC [NV] = '{
    {3'b000,3'd0,1'b1,1'b0,1'b1,3'd0,2'd0,5'd0, 3'b001,1'b0,1'b0,1'b0}, // R4 user read
    {3'b000,3'd4,1'b1,1'b0,1'b1,3'd0,2'd0,5'd8, 3'b000,1'b0,1'b1,1'b0}, // R2
    {3'b000,3'd6,1'b1,1'b0,1'b1,3'd0,2'd0,5'd12,3'b000,1'b0,1'b1,1'b0}, // R1
    {3'b001,3'd4,1'b1,1'b0,1'b1,3'd0,2'd0,5'd8, 3'b000,1'b0,1'b1,1'b0}, // R2
    {3'b001,3'd6,1'b1,1'b0,1'b1,3'd0,2'd0,5'd0, 3'b101,1'b0,1'b0,1'b0}, // R4
    {3'b010,3'd5,1'b1,1'b0,1'b1,3'd0,2'd0,5'd8, 3'b000,1'b1,1'b0,1'b0}, // R2 R10
    {3'b011,3'd7,1'b0,1'b0,1'b1,3'd0,2'd0,5'd0, 3'b101,1'b0,1'b0,1'b0}, // R5
    {3'b100,3'd5,1'b1,1'b0,1'b1,3'd0,2'd0,5'd8, 3'b000,1'b0,1'b1,1'b0}, // R2
    {3'b101,3'd5,1'b1,1'b0,1'b1,3'd0,2'd0,5'd0, 3'b011,1'b0,1'b0,1'b0}, // R4
    {3'b101,3'd6,1'b1,1'b0,1'b1,3'd0,2'd0,5'd8, 3'b000,1'b0,1'b1,1'b0}, // R2
    {3'b100,3'd3,1'b1,1'b0,1'b1,3'd0,2'd0,5'd0, 3'b111,1'b0,1'b0,1'b0}, // R4
    {3'b010,3'd7,1'b1,1'b1,1'b1,3'd0,2'd0,5'd0, 3'b000,1'b0,1'b0,1'b0}, // R3
    {3'b001,3'd4,1'b1,1'b1,1'b1,3'd0,2'd0,5'd8, 3'b111,1'b0,1'b0,1'b1}, // R9
    {3'b000,3'd4,1'b1,1'b0,1'b0,3'd0,2'd0,5'd8, 3'b111,1'b0,1'b0,1'b1}, // R9
    {3'b001,3'd3,1'b1,1'b0,1'b1,3'd1,2'd2,5'd4, 3'b000,1'b0,1'b1,1'b0}, // R6
    {3'b010,3'd3,1'b1,1'b0,1'b1,3'd4,2'd1,5'd16,3'b000,1'b1,1'b0,1'b0}, // R6 R10
    {3'b110,3'd3,1'b1,1'b0,1'b1,3'd0,2'd0,5'd0, 3'b111,1'b0,1'b0,1'b0}, // R2
    {3'b111,3'd6,1'b1,1'b0,1'b1,3'd0,2'd0,5'd8, 3'b000,1'b1,1'b0,1'b0}, // R2 R10
    {3'b000,3'd5,1'b0,1'b0,1'b1,3'd0,2'd0,5'd0, 3'b001,1'b0,1'b0,1'b0}, // R4
    {3'b000,3'd1,1'b0,1'b0,1'b1,3'd0,2'd0,5'd0, 3'b001,1'b0,1'b0,1'b0}, // R5
    {3'b000,3'd3,1'b1,1'b1,1'b1,3'd1,2'd3,5'd4, 3'b111,1'b0,1'b0,1'b1}, // R6 R9
    {3'b001,3'd0,1'b0,1'b0,1'b1,3'd0,2'd0,5'd0, 3'b001,1'b0,1'b0,1'b0}  // R5
  };

  logic clk = 1'b0;
  logic rst;
  logic req_valid, req_write, req_fetch, req_super;
  logic [2:0] pte_perm;
  logic pte_modified, nofault_mode, trap_en;
  logic [1:0] walk_level;
  logic [2:0] walk_err;
  logic [VA_W-1:0] req_vaddr;
  logic fsr_rd;
  logic rsp_valid;
  logic [4:0] rsp_err;
  logic [2:0] rsp_rights;
  logic rsp_override, itrap, dtrap;
  logic [9:0] fault_status;
  logic [VA_W-1:0] fault_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [VA_W-1:0] exp_far;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmu_perm_fault dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_fetch(req_fetch), .req_super(req_super), .pte_perm(pte_perm),
    .pte_modified(pte_modified), .nofault_mode(nofault_mode), .trap_en(trap_en),
    .walk_level(walk_level), .walk_err(walk_err), .req_vaddr(req_vaddr),
    .fsr_rd(fsr_rd), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rights(rsp_rights), .rsp_override(rsp_override), .itrap(itrap),
    .dtrap(dtrap), .fault_status(fault_status), .fault_addr(fault_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_write = 0; req_fetch = 0; req_super = 0;
    pte_perm = 0; pte_modified = 0; nofault_mode = 0; trap_en = 1;
    walk_level = 0; walk_err = 0; req_vaddr = '0; fsr_rd = 0;
  endtask

  // drive on falling edge, sample just after the next rising edge
  task automatic issue(input logic [2:0] idx, input logic [2:0] perm, input logic md,
                       input logic nf, input logic ten, input logic [2:0] werr,
                       input logic [1:0] lvl, input logic [VA_W-1:0] va, input logic rd);
    @(negedge clk);
    req_valid = 1; {req_write, req_fetch, req_super} = idx;
    pte_perm = perm; pte_modified = md; nofault_mode = nf; trap_en = ten;
    walk_err = werr; walk_level = lvl; req_vaddr = va; fsr_rd = rd;
    @(posedge clk); #1;
    req_valid = 0; fsr_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    rst = 0;
    // reset state (R12)
    check("R12 reset rsp_valid", 32'(rsp_valid), 0);
    check("R12 reset traps", 32'({itrap, dtrap}), 0);
    check("R7 reset status", 32'(fault_status), 0);
    check("R8 reset addr", 32'(fault_addr), 0);
    exp_far = '0;

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      logic [VA_W-1:0] va;
      logic [9:0] exp_fsr;
      v  = VEC[i];
      va = 32'h1234_5678 + 32'(i) * 32'h0101_0A37;
      issue(v[24:22], v[21:19], v[18], v[17], v[16], v[15:13], v[12:11], va, 1'b1);
      if (v[10:6] != 0) begin
        exp_fsr = {(v[15:13] != 0) ? v[12:11] : 2'b00, v[24:22], v[10:8], 2'b10};
        exp_far = {va[VA_W-1:12], 12'h000};
      end else begin
        exp_fsr = '0;
      end
      check($sformatf("R12 vec%0d valid", i), 32'(rsp_valid), 1);
      check($sformatf("R1/R2/R3/R6 vec%0d err", i), 32'(rsp_err), 32'(v[10:6]));
      check($sformatf("R4/R5/R9 vec%0d rights", i), 32'(rsp_rights), 32'(v[5:3]));
      check($sformatf("R10 vec%0d itrap", i), 32'(itrap), 32'(v[2]));
      check($sformatf("R10 vec%0d dtrap", i), 32'(dtrap), 32'(v[1]));
      check($sformatf("R9 vec%0d override", i), 32'(rsp_override), 32'(v[0]));
      check($sformatf("R7/R11 vec%0d status", i), 32'(fault_status), 32'(exp_fsr));
      check($sformatf("R8 vec%0d addr", i), fault_addr, exp_far);
    end

    // R12: response and trap last one cycle
    issue(3'b000, 3'd4, 1, 0, 1, 3'd0, 2'd0, 32'hA000_0123, 1'b1);
    check("R10 dtrap pulse", 32'(dtrap), 1);
    @(posedge clk); #1;
    check("R12 valid drops", 32'(rsp_valid), 0);
    check("R12 dtrap drops", 32'(dtrap), 0);

    // R7 overflow: second fault without read sets bit 0
    issue(3'b001, 3'd4, 1, 0, 1, 3'd0, 2'd0, 32'hB000_1FFF, 1'b0);
    check("R7 overflow status", 32'(fault_status), 32'(10'b00_001_010_11));
    check("R8 second addr", fault_addr, 32'hB000_1000);

    // R8: non-faulting access leaves address alone; R11 read clears
    issue(3'b001, 3'd3, 1, 0, 1, 3'd0, 2'd0, 32'hC000_0000, 1'b1);
    check("R8 addr held", fault_addr, 32'hB000_1000);
    check("R11 read clears", 32'(fault_status), 0);

    // R11: fault after read has no overflow
    issue(3'b000, 3'd6, 1, 0, 1, 3'd0, 2'd0, 32'hD000_0000, 1'b0);
    check("R11 no overflow", 32'(fault_status), 32'(10'b00_000_011_10));

    // R3: ignored user error leaves status untouched
    issue(3'b100, 3'd6, 1, 1, 1, 3'd0, 2'd0, 32'hE000_0000, 1'b0);
    check("R3 status kept", 32'(fault_status), 32'(10'b00_000_011_10));
    check("R3 addr kept", fault_addr, 32'hD000_0000);
    check("R3 no trap", 32'({itrap, dtrap}), 0);

    // R12: no request means nothing happens
    @(negedge clk);
    req_write = 1; pte_perm = 3'd0; fsr_rd = 0;
    @(posedge clk); #1;
    check("R12 idle valid", 32'(rsp_valid), 0);
    check("R12 idle status", 32'(fault_status), 32'(10'b00_000_011_10));
    idle_inputs();

    finish_run();
  end
endmodule